// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Register Unit

This block holds the interrupt register, the controller status register and the two system configuration registers of a flash memory controller's register window. It takes completion and error events from the command engine and records them. It drives an interrupt line whose polarity is set by software, and a ready line that is set by software. It also decides whether a command written by software may reach the command engine. A new command is accepted only while the master interrupt bit is clear. This forces software to acknowledge one operation before it starts the next.

Software reaches the block through a 16-bit register port. Reads are registered, so the read data appears one clock edge after the address. The command engine reports each finished operation as a one-cycle event. An event carries a kind code, an error flag and an unknown-command flag. A synchronous reset input puts the registers into their start state. A companion input selects whether that reset is cold or warm.

Register addresses (`reg_addr`) are: 0 configuration 1, 1 configuration 2, 2 controller status, 3 interrupt, 4 command. Other addresses read as zero and ignore writes.

Top module: `flash_irq_status_regs`

## Requirements
- R1: While `rst` is high at a clock edge, the registers take these values: configuration 1 = 0x40C0, configuration 2 = 0x0000, status = 0x0000, command = 0x0000. The interrupt register takes 0x8080 when `rst_cold` is 1 and 0x8010 when it is 0. `rdy` is 1 after either reset.
- R2: Reading configuration 1 returns the stored value with bits 4..0 forced to zero. Configuration 2 reads back exactly as written.
- R3: `irq` equals interrupt bit 15 when configuration 1 bit 6 is 1. It equals the inverse of interrupt bit 15 when configuration 1 bit 6 is 0. `irq` follows register changes with no added cycle.
- R4: A write to the interrupt register stores the bitwise AND of the written value and the old contents. Writing 0 to a bit clears it; writing 1 leaves it unchanged.
- R5: When an interrupt-register write leaves bit 15 at 0, status bits 10, 11, 12 and 13 are cleared. When bit 15 stays 1, the status register is kept.
- R6: A command-register write while interrupt bit 15 is 1 is ignored: `cmd_start` stays low and the command read-back is unchanged. Otherwise the command is stored and `cmd_start` pulses for one cycle with `cmd_code` equal to the written value.
- R7: An event with `evt_kind` of 1 (erase), 2 (program) or 3 (load) sets interrupt bit 15 and bit 5, 6 or 7 respectively. Kind 0 sets only bit 15. When `evt_err` is also 1, status bit 10 is set, together with bit 11, 12 or 13 for kinds 1, 2 and 3.
- R8: An event with `evt_badcmd` = 1 sets status bit 10 and interrupt bit 15.
- R9: Writing configuration 1 sets `rdy` to bit 7 of the written value at that edge.
- R10: When an interrupt-register write and an event happen in the same cycle, the write is applied first. The bits set by the event are then ORed in, so they are never lost.
- R11: `rd_data` changes only on a clock edge. It shows the register selected by `reg_addr` at that edge, with its value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_cold | input | 1 | Reset kind while `rst` is high: 1 cold, 0 warm |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| evt_valid | input | 1 | One-cycle event from the command engine |
| evt_kind | input | 2 | 0 generic, 1 erase, 2 program, 3 load |
| evt_err | input | 1 | The reported operation failed |
| evt_badcmd | input | 1 | The command was not recognised |
| cmd_start | output | 1 | One-cycle pulse when a command is accepted |
| cmd_code | output | 16 | Accepted command code |
| irq | output | 1 | Interrupt line, polarity from configuration 1 bit 6 |
| rdy | output | 1 | Ready line from configuration 1 bit 7 |

## Verification
The interrupt-acknowledge write and a completion event from the command engine can land on the same edge. The bench provokes this by holding an interrupt write of all zeros together with an erroring load event for one cycle, while status error bits from an earlier event are still set. It then expects the new completion and error bits to survive: interrupt 0x8080 and status 0x2400. The earlier error bit 10 is cleared by the write and set again by the event.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    A_CFG1 = 3'd0,
    A_CFG2 = 3'd1,
    A_STAT = 3'd2,
    A_INTR = 3'd3,
    A_CMD  = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    K_PLAIN = 2'd0,
    K_ERASE = 2'd1,
    K_PROG  = 2'd2,
    K_LOAD  = 2'd3
  } evt_kind_e;

  localparam logic [DATA_W-1:0] CFG1_INIT  = 16'h40C0;
  localparam logic [DATA_W-1:0] CFG2_INIT  = 16'h0000;
  localparam logic [DATA_W-1:0] INTR_COLD  = 16'h8080;
  localparam logic [DATA_W-1:0] INTR_WARM  = 16'h8010;
  localparam logic [DATA_W-1:0] CFG1_RMASK = 16'hFFE0;

  localparam int B_MASTER = 15;
  localparam int B_POL    = 6;
  localparam int B_RDY    = 7;
  localparam int B_ECMD   = 10;
  localparam logic [DATA_W-1:0] ERR_MASK = 16'h3C00;
endpackage

// File: rtl/isr_cfg_regs.sv
module isr_cfg_regs
  import isr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cfg1,
  input  logic              wr_cfg2,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg1_q,
  output logic [DATA_W-1:0] cfg2_q,
  output logic              rdy_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg1_q <= CFG1_INIT;
      cfg2_q <= CFG2_INIT;
      rdy_q  <= 1'b1;
    end else begin
      if (wr_cfg1) begin
        cfg1_q <= wdata;
        rdy_q  <= wdata[B_RDY];
      end
      if (wr_cfg2) cfg2_q <= wdata;
    end
  end
endmodule

// File: rtl/isr_event_regs.sv
module isr_event_regs
  import isr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_cold,
  input  logic              wr_intr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evt_valid,
  input  logic [1:0]        evt_kind,
  input  logic              evt_err,
  input  logic              evt_badcmd,
  output logic [DATA_W-1:0] int_q,
  output logic [DATA_W-1:0] stat_q
);
  logic [DATA_W-1:0] int_masked, stat_masked, int_set, stat_set;

  always_comb begin
    int_set  = '0;
    stat_set = '0;
    if (evt_valid) begin
      int_set[B_MASTER] = 1'b1;
      case (evt_kind)
        K_ERASE: int_set[5] = 1'b1;
        K_PROG:  int_set[6] = 1'b1;
        K_LOAD:  int_set[7] = 1'b1;
        default: ;
      endcase
      if (evt_err || evt_badcmd) stat_set[B_ECMD] = 1'b1;
      if (evt_err) begin
        case (evt_kind)
          K_ERASE: stat_set[11] = 1'b1;
          K_PROG:  stat_set[12] = 1'b1;
          K_LOAD:  stat_set[13] = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    int_masked  = wr_intr ? (int_q & wdata) : int_q;
    stat_masked = (wr_intr && !int_masked[B_MASTER]) ? (stat_q & ~ERR_MASK) : stat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q  <= rst_cold ? INTR_COLD : INTR_WARM;
      stat_q <= '0;
    end else begin
      int_q  <= int_masked | int_set;
      stat_q <= stat_masked | stat_set;
    end
  end
endmodule

// File: rtl/isr_cmd_gate.sv
module isr_cmd_gate
  import isr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cmd,
  input  logic              busy,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cmd_q,
  output logic              start_q
);
  logic accept;
  assign accept = wr_cmd && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= accept;
      if (accept) cmd_q <= wdata;
    end
  end
endmodule

// File: rtl/flash_irq_status_regs.sv
module flash_irq_status_regs
  import isr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_cold,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       rd_data,
  input  logic              evt_valid,
  input  logic [1:0]        evt_kind,
  input  logic              evt_err,
  input  logic              evt_badcmd,
  output logic              cmd_start,
  output logic [15:0]       cmd_code,
  output logic              irq,
  output logic              rdy
);
  logic [DATA_W-1:0] cfg1_q, cfg2_q, int_q, stat_q, cmd_q;
  logic wr_cfg1, wr_cfg2, wr_intr, wr_cmd;

  assign wr_cfg1 = reg_wr && (reg_addr == ADDR_W'(A_CFG1));
  assign wr_cfg2 = reg_wr && (reg_addr == ADDR_W'(A_CFG2));
  assign wr_intr = reg_wr && (reg_addr == ADDR_W'(A_INTR));
  assign wr_cmd  = reg_wr && (reg_addr == ADDR_W'(A_CMD));

  isr_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .wr_cfg1(wr_cfg1), .wr_cfg2(wr_cfg2),
    .wdata(reg_wdata), .cfg1_q(cfg1_q), .cfg2_q(cfg2_q), .rdy_q(rdy)
  );

  isr_event_regs u_evt (
    .clk(clk), .rst(rst), .rst_cold(rst_cold), .wr_intr(wr_intr),
    .wdata(reg_wdata), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_err(evt_err), .evt_badcmd(evt_badcmd),
    .int_q(int_q), .stat_q(stat_q)
  );

  isr_cmd_gate u_cmd (
    .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .busy(int_q[B_MASTER]),
    .wdata(reg_wdata), .cmd_q(cmd_q), .start_q(cmd_start)
  );

  assign cmd_code = cmd_q;
  assign irq = int_q[B_MASTER] ^ ~cfg1_q[B_POL];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (reg_addr)
        ADDR_W'(A_CFG1): rd_data <= cfg1_q & CFG1_RMASK;
        ADDR_W'(A_CFG2): rd_data <= cfg2_q;
        ADDR_W'(A_STAT): rd_data <= stat_q;
        ADDR_W'(A_INTR): rd_data <= int_q;
        ADDR_W'(A_CMD):  rd_data <= cmd_q;
        default:         rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/isr_checker.sv
module isr_checker (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        evt_valid,
  input logic        evt_badcmd,
  input logic        cmd_start,
  input logic        rdy,
  input logic [15:0] int_q,
  input logic [15:0] stat_q
);
  AST_CMD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd4 && int_q[15]) |=> !cmd_start); // R6
  AST_EVT_MASTER: assert property (@(posedge clk) disable iff (rst)
    evt_valid |=> int_q[15]); // R7
  AST_ERR_WIPE: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd3 && !reg_wdata[15] && !evt_valid) |=> (stat_q[13:10] == 4'd0)); // R5
  AST_RDY_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 3'd0) |=> (rdy == $past(reg_wdata[7]))); // R9
  AST_BADCMD_FLAG: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_badcmd) |=> (stat_q[10] && int_q[15])); // R8
endmodule

bind flash_irq_status_regs isr_checker u_isr_checker (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .evt_valid(evt_valid), .evt_badcmd(evt_badcmd),
  .cmd_start(cmd_start), .rdy(rdy), .int_q(int_q), .stat_q(stat_q)
);

// File: tb/test_flash_irq_status_regs.sv
module test_flash_irq_status_regs;
  logic clk = 1'b0;
  logic rst = 1'b1, rst_cold = 1'b1;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] rd_data;
  logic evt_valid = 1'b0, evt_err = 1'b0, evt_badcmd = 1'b0;
  logic [1:0] evt_kind = 2'd0;
  logic cmd_start, irq, rdy;
  logic [15:0] cmd_code;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_irq_status_regs i_flash_irq_status_regs (
    .clk(clk), .rst(rst), .rst_cold(rst_cold), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_data(rd_data),
    .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_err(evt_err),
    .evt_badcmd(evt_badcmd), .cmd_start(cmd_start), .cmd_code(cmd_code),
    .irq(irq), .rdy(rdy)
  );

  // {addr, write value, expected read}
  localparam logic [34:0] VEC [6] = '{
    {3'd0, 16'hFFFF, 16'hFFE0},
    {3'd1, 16'h1234, 16'h1234},
    {3'd0, 16'h001F, 16'h0000},
    {3'd1, 16'hA5A5, 16'hA5A5},
    {3'd0, 16'h4CDD, 16'h4CC0},
    {3'd0, 16'h40C0, 16'h40C0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic evt(input logic [1:0] k, input logic e, input logic b);
    @(negedge clk);
    evt_valid = 1'b1; evt_kind = k; evt_err = e; evt_badcmd = b;
    @(posedge clk);
    @(negedge clk);
    evt_valid = 1'b0; evt_err = 1'b0; evt_badcmd = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 cold reset values
    rd(3'd3, v); check("R1 intr cold", v, 16'h8080);
    rd(3'd0, v); check("R1 cfg1", v, 16'h40C0);
    rd(3'd1, v); check("R1 cfg2", v, 16'h0000);
    rd(3'd2, v); check("R1 status", v, 16'h0000);
    check("R1 rdy", {15'd0, rdy}, 16'd1);
    check("R3 irq active-high set", {15'd0, irq}, 16'd1);

    // R2 table walk
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][34:32], VEC[i][31:16]);
      rd(VEC[i][34:32], v);
      check("R2 readback", v, VEC[i][15:0]);
    end

    // R6 command blocked while master set
    wr(3'd4, 16'h0094);
    check("R6 blocked start", {15'd0, cmd_start}, 16'd0);
    rd(3'd4, v); check("R6 blocked readback", v, 16'h0000);

    // R4 clear all
    wr(3'd3, 16'h0000);
    rd(3'd3, v); check("R4 cleared", v, 16'h0000);
    check("R3 irq low", {15'd0, irq}, 16'd0);

    // R6 accepted
    wr(3'd4, 16'h0094);
    check("R6 start pulse", {15'd0, cmd_start}, 16'd1);
    check("R6 code", cmd_code, 16'h0094);
    @(negedge clk);
    check("R6 single pulse", {15'd0, cmd_start}, 16'd0);

    // R7 erase error
    evt(2'd1, 1'b1, 1'b0);
    rd(3'd3, v); check("R7 erase intr", v, 16'h8020);
    rd(3'd2, v); check("R7 erase status", v, 16'h0C00);

    // R4/R5 partial clear keeps master, keeps errors
    wr(3'd3, 16'hFFDF);
    rd(3'd3, v); check("R4 and-write", v, 16'h8000);
    rd(3'd2, v); check("R5 kept", v, 16'h0C00);

    // R3 inverted polarity
    wr(3'd0, 16'h4080);
    check("R3 irq inverted set", {15'd0, irq}, 16'd0);
    wr(3'd3, 16'h7FFF);
    check("R3 irq inverted clear", {15'd0, irq}, 16'd1);
    rd(3'd2, v); check("R5 wiped", v, 16'h0000);
    wr(3'd0, 16'h40C0);

    // R7 program ok, then plain
    evt(2'd2, 1'b0, 1'b0);
    rd(3'd3, v); check("R7 program", v, 16'h8040);
    wr(3'd3, 16'h0000);
    evt(2'd0, 1'b0, 1'b0);
    rd(3'd3, v); check("R7 plain", v, 16'h8000);
    rd(3'd2, v); check("R7 no error", v, 16'h0000);

    // R8 unknown command
    evt(2'd0, 1'b0, 1'b1);
    rd(3'd2, v); check("R8 status", v, 16'h0400);
    rd(3'd3, v); check("R8 intr", v, 16'h8000);

    // R10 write and event in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 16'h0000;
    evt_valid = 1'b1; evt_kind = 2'd3; evt_err = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; evt_valid = 1'b0; evt_err = 1'b0;
    rd(3'd3, v); check("R10 intr", v, 16'h8080);
    rd(3'd2, v); check("R10 status", v, 16'h2400);

    // R11 rd_data holds between edges
    rd(3'd1, v);
    @(negedge clk);
    reg_addr = 3'd3;
    #1;
    check("R11 hold", rd_data, 16'hA5A5);

    // R9 ready
    wr(3'd0, 16'h4040);
    check("R9 rdy low", {15'd0, rdy}, 16'd0);
    wr(3'd0, 16'h40C0);
    check("R9 rdy high", {15'd0, rdy}, 16'd1);

    // R1 warm reset
    wr(3'd1, 16'h5555);
    @(negedge clk); rst = 1'b1; rst_cold = 1'b0;
    @(posedge clk);
    @(negedge clk); rst = 1'b0;
    rd(3'd3, v); check("R1 intr warm", v, 16'h8010);
    rd(3'd1, v); check("R1 cfg2 warm", v, 16'h0000);
    rd(3'd2, v); check("R1 status warm", v, 16'h0000);
    rd(3'd4, v); check("R1 cmd warm", v, 16'h0000);

    finish_run();
  end
endmodule